// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides, for each memory access, whether the access bypasses page translation. It holds four 32-bit window registers: two apply to data accesses and two apply to instruction fetches. Each window pairs an 8-bit base with an 8-bit ignore mask on the top address byte. A window is also gated by an enable bit, a privilege-mode field and a write-protect bit.

A lookup is combinational. The request carries a logical address, a fetch flag and a supervisor flag. Only the two windows of the matching access kind are checked, and the lower-numbered window wins when both match. On a hit the access is untranslated: the block returns the page-aligned logical address as the physical frame, together with read, execute and write permissions. On a miss the block raises `miss`, which hands the access to the page-table walker downstream.

Software reads and writes the four registers through a simple indexed port. The port has a 2-bit index, a write strobe and combinational read data.

Top module: `ttw_matcher`

## Requirements
- R1: After a synchronous active-low reset, all four registers read as zero, so every window is disabled and every lookup misses.
- R2: Writing through the port with index `cfg_idx` stores all 32 bits of `cfg_wdata`, and `cfg_rdata` returns the register selected by `cfg_idx` in the cycle after the write. Bits other than 31:13 and 2 are stored but do not affect lookups.
- R3: Register indices are 0 and 1 for data windows and 2 and 3 for fetch windows. A lookup with `req_ifetch`=1 checks only registers 2 and 3. Any other lookup checks only registers 0 and 1.
- R4: A register with bit 15 clear never matches.
- R5: Bits 14:13 form the mode field. The value 00 matches only when `req_super`=0, the value 01 matches only when `req_super`=1, and the values 10 and 11 match in either mode.
- R6: Bits 31:24 hold the base and bits 23:16 hold the mask. An address matches when, for every mask bit that is 0, the corresponding address bit in 31:24 equals the base bit. A mask of 0xFF matches any address.
- R7: When both windows of a kind match, the lower index decides the result. `hit_idx` reports the register index (0 to 3) of the deciding window.
- R8: A hit sets `perm_rd` and `perm_ex`. It sets `perm_wr` only when bit 2 (write protect) of the deciding register is 0.
- R9: On a hit, `phys_addr` equals `req_addr` with its low 12 bits cleared, which gives a 4 KiB frame.
- R10: On a miss, `miss`=1, `hit`=0, `hit_idx`=0, `phys_addr`=0 and all three permissions are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_idx | input | 2 | Register index for read and write |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Contents of the register selected by cfg_idx |
| req_addr | input | 32 | Logical address of the access |
| req_ifetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| req_super | input | 1 | 1 for a supervisor-mode access |
| hit | output | 1 | The access is transparently translated |
| miss | output | 1 | The access needs the page-table walk |
| hit_idx | output | 2 | Register index of the deciding window |
| phys_addr | output | 32 | Page-aligned physical frame address on a hit |
| perm_rd | output | 1 | Read permitted |
| perm_wr | output | 1 | Write permitted |
| perm_ex | output | 1 | Execute permitted |

## Verification
The assertions assume the request inputs are settled when sampled at the rising clock edge. They also assume `cfg_we` is held low while reset is active, so a write is never expected to land during reset. The bench drives every input on the falling edge, keeps the write strobe low throughout reset, and samples lookup results one time unit after it drives them. The table rewrites the whole bank before each lookup and clears the other bank, so each expected result depends only on that table row.

// File: rtl/ttw_pkg.sv
// Package: field positions and shared types for the transparent window matcher.
// Assumes a 32-bit register layout in which the base and mask cover the top address byte.
package ttw_pkg;
    localparam int TTW_DATA_W  = 32;
    localparam int TTW_EN_BIT  = 15;
    localparam int TTW_MODE_HI = 14;
    localparam int TTW_MODE_LO = 13;
    localparam int TTW_WP_BIT  = 2;
    localparam int TTW_BASE_HI = 31;
    localparam int TTW_BASE_LO = 24;
    localparam int TTW_MASK_HI = 23;
    localparam int TTW_MASK_LO = 16;
    localparam int TTW_BYTE_W  = TTW_BASE_HI - TTW_BASE_LO + 1;

    typedef enum logic [1:0] {
        MODE_USER  = 2'b00,
        MODE_SUPER = 2'b01,
        MODE_ANY_A = 2'b10,
        MODE_ANY_B = 2'b11
    } ttw_mode_e;
endpackage

// File: rtl/ttw_regfile.sv
// Module: window register file. Holds NUM_REGS registers with one indexed write
// port and a combinational read port. Assumes idx is always below NUM_REGS.
module ttw_regfile #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [IDX_W-1:0]                 idx,
    input  logic                             we,
    input  logic [DATA_W-1:0]                wdata,
    output logic [DATA_W-1:0]                rdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
    // Register storage: cleared on reset, one register updated per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (we) begin
            regs_q[idx] <= wdata;
        end
    end

    // Read port: returns the register selected by idx.
    always_comb begin
        rdata = regs_q[idx];
    end
endmodule

// File: rtl/ttw_window_check.sv
// Module: compares one window register against an access. It reports a match
// from the enable bit, the mode field and the masked top address byte, and it
// reports whether the window allows writes. Purely combinational.
module ttw_window_check
    import ttw_pkg::*;
(
    input  logic [TTW_DATA_W-1:0] win_val,
    input  logic [TTW_BYTE_W-1:0] addr_top,
    input  logic                  is_super,
    output logic                  match,
    output logic                  wr_ok
);
    logic            mode_ok;
    logic            addr_ok;
    logic [TTW_BYTE_W-1:0] care;
    ttw_mode_e       mode;

    // Mode gate: user-only, supervisor-only or either mode.
    always_comb begin
        mode = ttw_mode_e'(win_val[TTW_MODE_HI:TTW_MODE_LO]);
        case (mode)
            MODE_USER:  mode_ok = !is_super;
            MODE_SUPER: mode_ok = is_super;
            default:    mode_ok = 1'b1;
        endcase
    end

    // Address gate: compare only the bits that the mask does not ignore.
    always_comb begin
        care    = ~win_val[TTW_MASK_HI:TTW_MASK_LO];
        addr_ok = ((addr_top ^ win_val[TTW_BASE_HI:TTW_BASE_LO]) & care) == '0;
    end

    // Combine the gates and derive write permission.
    always_comb begin
        match = win_val[TTW_EN_BIT] && mode_ok && addr_ok;
        wr_ok = !win_val[TTW_WP_BIT];
    end
endmodule

// File: rtl/ttw_prio.sv
// Module: fixed-priority picker. Returns the lowest set request index and
// whether any request is set. Index 0 has the highest priority.
module ttw_prio #(
    parameter int N        = 4,
    localparam int IDX_W   = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so that the lowest set index is written last and wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ttw_matcher.sv
// Module: transparent translation window matcher (top). It stores the window
// registers, checks the bank that belongs to the access kind, picks the
// lowest-index match and produces the untranslated frame and permissions.
// Assumes the request inputs are stable for the whole cycle of a lookup.
module ttw_matcher
    import ttw_pkg::*;
#(
    parameter int WIN_PER_KIND = 2,
    parameter int NUM_KINDS    = 2,
    parameter int PAGE_BITS    = 12,
    localparam int NUM_REGS    = WIN_PER_KIND * NUM_KINDS,
    localparam int IDX_W       = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic                  cfg_we,
    input  logic [TTW_DATA_W-1:0] cfg_wdata,
    output logic [TTW_DATA_W-1:0] cfg_rdata,
    input  logic [TTW_DATA_W-1:0] req_addr,
    input  logic                  req_ifetch,
    input  logic                  req_super,
    output logic                  hit,
    output logic                  miss,
    output logic [IDX_W-1:0]      hit_idx,
    output logic [TTW_DATA_W-1:0] phys_addr,
    output logic                  perm_rd,
    output logic                  perm_wr,
    output logic                  perm_ex
);
    localparam logic [TTW_DATA_W-1:0] FRAME_MASK =
        ~((TTW_DATA_W'(1) << PAGE_BITS) - TTW_DATA_W'(1));

    logic [NUM_REGS-1:0][TTW_DATA_W-1:0] regs_q;
    logic [NUM_REGS-1:0] win_match;
    logic [NUM_REGS-1:0] win_wr_ok;
    logic [NUM_REGS-1:0] bank_match;
    logic                any_hit;
    logic [IDX_W-1:0]    sel_idx;

    ttw_regfile #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (TTW_DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (cfg_idx),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .regs_q (regs_q)
    );

    // One comparator per register; each register is gated to its own access kind.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_win
        localparam int KIND = g / WIN_PER_KIND;
        ttw_window_check u_chk (
            .win_val  (regs_q[g]),
            .addr_top (req_addr[TTW_BASE_HI:TTW_BASE_LO]),
            .is_super (req_super),
            .match    (win_match[g]),
            .wr_ok    (win_wr_ok[g])
        );
        // Bank gate: kind 1 holds the fetch windows and kind 0 the data windows.
        always_comb begin
            bank_match[g] = win_match[g] && ((KIND == 1) == req_ifetch);
        end
    end

    ttw_prio #(.N(NUM_REGS)) u_prio (
        .req (bank_match),
        .any (any_hit),
        .idx (sel_idx)
    );

    // Result drive: untranslated frame and permissions on a hit, all zero on a miss.
    always_comb begin
        hit       = any_hit;
        miss      = !any_hit;
        hit_idx   = any_hit ? sel_idx : '0;
        phys_addr = any_hit ? (req_addr & FRAME_MASK) : '0;
        perm_rd   = any_hit;
        perm_ex   = any_hit;
        perm_wr   = any_hit && win_wr_ok[sel_idx];
    end
endmodule

// File: rtl/ttw_matcher_chk.sv
// Module: assertion checker for ttw_matcher, attached with bind. It assumes
// cfg_we is low while reset is active.
module ttw_matcher_chk #(
    parameter int PAGE_BITS = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_idx,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic [31:0] req_addr,
    input logic        req_ifetch,
    input logic        hit,
    input logic        miss,
    input logic [1:0]  hit_idx,
    input logic [31:0] phys_addr,
    input logic        perm_rd,
    input logic        perm_wr,
    input logic        perm_ex
);
    a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && cfg_idx == $past(cfg_idx))
            |-> cfg_rdata == $past(cfg_wdata));

    a_r3_bank_kind: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> hit_idx[1] == req_ifetch);

    a_r8_read_exec: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (perm_rd && perm_ex));

    a_r9_frame: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (phys_addr[31:PAGE_BITS] == req_addr[31:PAGE_BITS]
                 && phys_addr[PAGE_BITS-1:0] == '0));

    a_r10_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (!hit && !perm_rd && !perm_wr && !perm_ex
                  && phys_addr == '0 && hit_idx == '0));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({hit, miss}) == 1);
endmodule

bind ttw_matcher ttw_matcher_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_idx    (cfg_idx),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .req_addr   (req_addr),
    .req_ifetch (req_ifetch),
    .hit        (hit),
    .miss       (miss),
    .hit_idx    (hit_idx),
    .phys_addr  (phys_addr),
    .perm_rd    (perm_rd),
    .perm_wr    (perm_wr),
    .perm_ex    (perm_ex)
);

// File: tb/tb_ttw_matcher.sv
// Bench for ttw_matcher: a table of lookups followed by directed reset and corner tests.
module tb_ttw_matcher;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] req_addr = '0;
    logic        req_ifetch = 1'b0;
    logic        req_super = 1'b0;
    logic        hit, miss, perm_rd, perm_wr, perm_ex;
    logic [1:0]  hit_idx;
    logic [31:0] phys_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ttw_matcher dut (
        .clk(clk), .rst_n(rst_n), .cfg_idx(cfg_idx), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
        .req_ifetch(req_ifetch), .req_super(req_super), .hit(hit), .miss(miss),
        .hit_idx(hit_idx), .phys_addr(phys_addr), .perm_rd(perm_rd),
        .perm_wr(perm_wr), .perm_ex(perm_ex)
    );

    // Row layout: {win_a, win_b, addr, ifetch, super, exp_hit, exp_idx[1:0], exp_wr}
    localparam logic [101:0] VEC [NV] = '{
        {32'h1200_8000, 32'h0, 32'h1234_5678, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1}, // R5 user-only, user
        {32'h1200_8000, 32'h0, 32'h1234_5678, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0}, // R5 user-only, super
        {32'h1200_A000, 32'h0, 32'h12FF_0000, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1}, // R5 super-only, super
        {32'h1200_A000, 32'h0, 32'h12FF_0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, // R5 super-only, user
        {32'h1200_C000, 32'h0, 32'h1200_0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1}, // R5 mode 10, user
        {32'h1200_C000, 32'h0, 32'h1200_0000, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1}, // R5 mode 10, super
        {32'h1200_E000, 32'h0, 32'h1200_0FFF, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1}, // R5 mode 11, user
        {32'h1200_E000, 32'h0, 32'h1200_0FFF, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1}, // R5 mode 11, super
        {32'h12FF_8000, 32'h0, 32'hABCD_EF01, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1}, // R6 fully masked
        {32'h1200_0000, 32'h0, 32'h1200_0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, // R4 disabled
        {32'h1200_8000, 32'h3400_8004, 32'h3400_1000, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0}, // R7 second only, R8 WP
        {32'h1200_8004, 32'h1200_8000, 32'h1200_0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0}, // R7 both, first wins
        {32'h4000_8000, 32'h0, 32'h4000_2000, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1}, // R3 fetch bank first
        {32'h0, 32'h500F_8000, 32'h5A00_0000, 1'b1, 1'b0, 1'b1, 2'd3, 1'b1}, // R3 R6 partial mask hit
        {32'h500F_8000, 32'h0, 32'h6000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}  // R6 partial mask miss
    };

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] i, input logic [31:0] d);
        @(negedge clk);
        cfg_idx = i; cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] i, output logic [31:0] d);
        @(negedge clk);
        cfg_idx = i;
        #1 d = cfg_rdata;
    endtask

    // Drives a lookup and checks the complete result against a hand-built expectation.
    task automatic lookup(input logic [31:0] a, input logic f, input logic s,
                          input logic eh, input logic [1:0] ei, input logic ew,
                          input string tag);
        logic [38:0] act, exp;
        @(negedge clk);
        req_addr = a; req_ifetch = f; req_super = s;
        #1;
        act = {hit, miss, hit_idx, perm_rd, perm_wr, perm_ex, phys_addr};
        exp = {eh, !eh, eh ? ei : 2'd0, eh, eh & ew, eh,
               eh ? {a[31:12], 12'h000} : 32'h0};
        check(64'(act), 64'(exp), tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register, and a lookup that misses
        for (int i = 0; i < 4; i++) begin
            cfg_read(2'(i), rd);
            check(64'(rd), 64'h0, "R1 reset register value");
        end
        lookup(32'h0000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R1 R10 lookup after reset");

        // Table walk: program the bank for the access kind and clear the other bank
        for (int v = 0; v < NV; v++) begin
            logic [101:0] r;
            logic [1:0] b;
            r = VEC[v];
            b = r[5] ? 2'd2 : 2'd0;
            cfg_write(b, r[101:70]);
            cfg_write(b + 2'd1, r[69:38]);
            cfg_write(b ^ 2'd2, 32'h0);
            cfg_write((b ^ 2'd2) + 2'd1, 32'h0);
            lookup(r[37:6], r[5], r[4], r[3], r[2:1], r[0],
                   $sformatf("R3 R4 R5 R6 R7 R8 R9 R10 table row %0d", v));
        end

        // R2: full-width storage and readback through each index
        for (int i = 0; i < 4; i++) cfg_write(2'(i), 32'hA5A5_0000 | 32'(i));
        for (int i = 0; i < 4; i++) begin
            cfg_read(2'(i), rd);
            check(64'(rd), 64'(32'hA5A5_0000 | 32'(i)), "R2 readback by index");
        end

        // R2 R8: other bits set, with write protect clear, leave the match and write grant unchanged
        cfg_write(2'd0, 32'h1200_9FFB);
        cfg_write(2'd1, 32'h0);
        lookup(32'h1200_4321, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, "R2 R8 other bits ignored");

        // R3: a data window that matches everything does not serve fetches
        cfg_write(2'd0, 32'h00FF_E000);
        cfg_write(2'd2, 32'h0);
        cfg_write(2'd3, 32'h0);
        lookup(32'h7777_7000, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, "R3 fetch ignores data bank");
        lookup(32'h7777_7000, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, "R3 data uses data bank");

        // R1: a reset in mid-run clears the registers again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cfg_read(2'd0, rd);
        check(64'(rd), 64'h0, "R1 reset clears register 0");
        lookup(32'h7777_7000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R1 R10 miss after second reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule